// File: doc/BRIEF.md
# Reset Supervisor Timing Controller

This block produces a processor reset from two asynchronous sources. The first is a supply-undervoltage flag from an external comparator, active high. The second is a manual reset request, active low, for example from a push button. Each source first passes through a two-flop synchroniser. It then passes a minimum-width qualifier, so that short glitches never reach the reset output. Reset is asserted while either qualified source is present.

When the last active source clears, one shared stretch timer holds reset asserted for a fixed timeout. A qualified source that reappears during the timeout reloads the timer to its full value. The block also comes out of its own initial reset with reset asserted, and it completes one full timeout before the first release. All durations are given in nanoseconds and converted to clock cycles from a clock-frequency parameter. A mode parameter selects how the output is driven. In driven mode the enable is always on. In open-drain style the enable is on only while reset is asserted.

Top module: `rst_supervisor`

## Requirements
- R1: After `rstN` deasserts, `resetN` stays low for at least HOLD cycles (HOLD = ceil(CLK_HZ·HOLD_NS/1e9)) and goes high within HOLD+2 cycles, with no source active.
- R2: A `manualRstN` low level held for MANUAL_MIN cycles or more (MANUAL_MIN derived from MANUAL_MIN_NS) drives `resetN` low, no earlier than MANUAL_MIN+1 cycles after the input falls.
- R3: A `manualRstN` low pulse shorter than MANUAL_MIN cycles leaves `resetN` high.
- R4: A `supplyLow` high level held for SUPPLY_MIN cycles or more (derived from SUPPLY_MIN_NS) drives `resetN` low, no earlier than SUPPLY_MIN+1 cycles after the input rises.
- R5: A `supplyLow` high pulse shorter than SUPPLY_MIN cycles leaves `resetN` high.
- R6: Once the last qualified source clears, `resetN` stays low for at least HOLD cycles and rises within HOLD+5 cycles of the input release.
- R7: While either qualified source is present, `resetN` is low. The stretch timer starts only when the last source releases, so an earlier release of the other source does not shorten the hold.
- R8: A source that qualifies again during the stretch reloads the full timeout, counted from its own release.
- R9: With OPEN_DRAIN=0, `resetOe` is constantly 1. With OPEN_DRAIN=1, `resetOe` is 1 exactly while `resetN` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, frequency CLK_HZ |
| rstN | input | 1 | Asynchronous initial reset of the block, active low |
| supplyLow | input | 1 | Asynchronous undervoltage flag, active high |
| manualRstN | input | 1 | Asynchronous manual reset request, active low |
| resetN | output | 1 | Processor reset level, active low |
| resetOe | output | 1 | Output enable for the reset pad |

## Verification
The bench keeps CLK_HZ at 250 MHz and sets the duration targets to 40 ns, 100 ns and 400 ns. This gives a manual qualification of 10 cycles, a supply qualification of 25 cycles and a hold of 100 cycles. At these sizes, pulses just below and just above each qualification width can be run in a few dozen cycles. Overlapping releases and a retrigger in the middle of the stretch also fit well inside the run. A second instance with OPEN_DRAIN=1 shares the same inputs, so both enable styles are compared at every check point.

// File: rtl/rsup_pkg.sv
package rsup_pkg;

  typedef enum logic [1:0] {
    ST_HOLD    = 2'd0,
    ST_STRETCH = 2'd1,
    ST_RUN     = 2'd2
  } supState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic timerLoad;
    logic timerStep;
  } timerCmd_t;

  // ceil(clkHz * ns / 1e9), computed in two steps to stay inside 64 bits
  function automatic longint nsToCycles(input longint clkHz, input longint ns);
    longint prod;
    prod = (clkHz / 1000) * ns;
    return (prod + 999_999) / 1_000_000;
  endfunction

endpackage

// File: rtl/rsup_qualifier.sv
module rsup_qualifier #(
  parameter int CYCLES      = 250,
  parameter bit ACTIVE_HIGH = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic syncActive,
  output logic qualified
);
  localparam int  CW       = $clog2(CYCLES + 1);
  localparam logic IDLE_LV = ~ACTIVE_HIGH;

  logic syncA, syncB;
  logic [CW-1:0] widthCnt;

  // two-flop synchroniser, parked at the inactive level in reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= IDLE_LV;
      syncB <= IDLE_LV;
    end else begin
      syncA <= rawIn;
      syncB <= syncA;
    end
  end

  assign syncActive = (syncB != IDLE_LV);

  // consecutive-active counter, saturating at the qualification width
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      widthCnt <= '0;
    end else if (!syncActive) begin
      widthCnt <= '0;
    end else if (widthCnt != CW'(CYCLES)) begin
      widthCnt <= widthCnt + 1'b1;
    end
  end

  assign qualified = (widthCnt == CW'(CYCLES));

endmodule

// File: rtl/rsup_datapath.sv
module rsup_datapath
  import rsup_pkg::*;
#(
  parameter int MR_CYC   = 250,
  parameter int SUP_CYC  = 5000,
  parameter int HOLD_CYC = 25_000_000
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      supplyLow,
  input  logic      manualRstN,
  input  timerCmd_t cmd,
  output logic      supSync,
  output logic      mrSync,
  output logic      supQual,
  output logic      mrQual,
  output logic      timerLast
);
  localparam int TW = $clog2(HOLD_CYC + 1);

  logic [TW-1:0] holdCnt;

  rsup_qualifier #(.CYCLES(SUP_CYC), .ACTIVE_HIGH(1'b1)) u_supQual (
    .clk        (clk),
    .rstN       (rstN),
    .rawIn      (supplyLow),
    .syncActive (supSync),
    .qualified  (supQual)
  );

  rsup_qualifier #(.CYCLES(MR_CYC), .ACTIVE_HIGH(1'b0)) u_mrQual (
    .clk        (clk),
    .rstN       (rstN),
    .rawIn      (manualRstN),
    .syncActive (mrSync),
    .qualified  (mrQual)
  );

  // stretch timer: starts full so the first release also waits a timeout
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt <= TW'(HOLD_CYC);
    end else if (cmd.timerLoad) begin
      holdCnt <= TW'(HOLD_CYC);
    end else if (cmd.timerStep && holdCnt != '0) begin
      holdCnt <= holdCnt - 1'b1;
    end
  end

  assign timerLast = (holdCnt == TW'(1));

endmodule

// File: rtl/rsup_control.sv
module rsup_control
  import rsup_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      anyQual,
  input  logic      timerLast,
  output timerCmd_t cmd,
  output logic      resetN
);
  supState_e state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_STRETCH;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    cmd       = '0;
    unique case (state)
      ST_HOLD: begin
        cmd.timerLoad = 1'b1;
        if (!anyQual) nextState = ST_STRETCH;
      end
      ST_STRETCH: begin
        if (anyQual) begin
          cmd.timerLoad = 1'b1;
          nextState     = ST_HOLD;
        end else begin
          cmd.timerStep = 1'b1;
          if (timerLast) nextState = ST_RUN;
        end
      end
      ST_RUN: begin
        if (anyQual) begin
          cmd.timerLoad = 1'b1;
          nextState     = ST_HOLD;
        end
      end
      default: nextState = ST_STRETCH;
    endcase
  end

  assign resetN = (state == ST_RUN);

endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor
  import rsup_pkg::*;
#(
  parameter longint CLK_HZ        = 250_000_000,
  parameter longint MANUAL_MIN_NS = 1_000,
  parameter longint SUPPLY_MIN_NS = 20_000,
  parameter longint HOLD_NS       = 100_000_000,
  parameter bit     OPEN_DRAIN    = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic supplyLow,
  input  logic manualRstN,
  output logic resetN,
  output logic resetOe
);
  localparam int MR_RAW   = int'(nsToCycles(CLK_HZ, MANUAL_MIN_NS));
  localparam int SUP_RAW  = int'(nsToCycles(CLK_HZ, SUPPLY_MIN_NS));
  localparam int HOLD_RAW = int'(nsToCycles(CLK_HZ, HOLD_NS));
  localparam int MR_CYC   = (MR_RAW   < 1) ? 1 : MR_RAW;
  localparam int SUP_CYC  = (SUP_RAW  < 1) ? 1 : SUP_RAW;
  localparam int HOLD_CYC = (HOLD_RAW < 1) ? 1 : HOLD_RAW;

  timerCmd_t timerCmd;
  logic supSyncAct, mrSyncAct, supQual, mrQual, timerLast, anyQual;

  rsup_datapath #(
    .MR_CYC   (MR_CYC),
    .SUP_CYC  (SUP_CYC),
    .HOLD_CYC (HOLD_CYC)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .supplyLow  (supplyLow),
    .manualRstN (manualRstN),
    .cmd        (timerCmd),
    .supSync    (supSyncAct),
    .mrSync     (mrSyncAct),
    .supQual    (supQual),
    .mrQual     (mrQual),
    .timerLast  (timerLast)
  );

  assign anyQual = supQual | mrQual;

  rsup_control u_control (
    .clk       (clk),
    .rstN      (rstN),
    .anyQual   (anyQual),
    .timerLast (timerLast),
    .cmd       (timerCmd),
    .resetN    (resetN)
  );

  generate
    if (OPEN_DRAIN) begin : g_openDrain
      assign resetOe = ~resetN;
    end else begin : g_pushPull
      assign resetOe = 1'b1;
    end
  endgenerate

endmodule

// File: rtl/rsup_checker.sv
module rsup_checker #(
  parameter int MR_CYC     = 250,
  parameter int SUP_CYC    = 5000,
  parameter int HOLD_CYC   = 25_000_000,
  parameter bit OPEN_DRAIN = 1'b0
) (
  input logic clk,
  input logic rstN,
  input logic mrSync,
  input logic supSync,
  input logic mrQual,
  input logic supQual,
  input logic resetN,
  input logic resetOe
);
  logic [31:0] mrRun, supRun, quietRun;
  logic anyQual;
  assign anyQual = mrQual | supQual;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mrRun    <= '0;
      supRun   <= '0;
      quietRun <= '0;
    end else begin
      mrRun    <= !mrSync  ? '0 : (mrRun    == '1 ? mrRun    : mrRun    + 1);
      supRun   <= !supSync ? '0 : (supRun   == '1 ? supRun   : supRun   + 1);
      quietRun <= anyQual  ? '0 : (quietRun == '1 ? quietRun : quietRun + 1);
    end
  end

  assert_mr_min_width_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mrQual) |-> (mrRun >= 32'(MR_CYC)));

  assert_sup_min_width_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(supQual) |-> (supRun >= 32'(SUP_CYC)));

  assert_source_holds_reset_R7: assert property (@(posedge clk) disable iff (!rstN)
    anyQual |=> !resetN);

  assert_full_stretch_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resetN) |-> (quietRun >= 32'(HOLD_CYC)));

  assert_oe_mode_R9: assert property (@(posedge clk) disable iff (!rstN)
    OPEN_DRAIN ? (resetOe == !resetN) : resetOe);

endmodule

bind rst_supervisor rsup_checker #(
  .MR_CYC     (MR_CYC),
  .SUP_CYC    (SUP_CYC),
  .HOLD_CYC   (HOLD_CYC),
  .OPEN_DRAIN (OPEN_DRAIN)
) u_checker (
  .clk     (clk),
  .rstN    (rstN),
  .mrSync  (mrSyncAct),
  .supSync (supSyncAct),
  .mrQual  (mrQual),
  .supQual (supQual),
  .resetN  (resetN),
  .resetOe (resetOe)
);

// File: tb/test_rst_supervisor.sv
module test_rst_supervisor;
  localparam int MRC = 10;   // 40 ns at 250 MHz
  localparam int SPC = 25;   // 100 ns
  localparam int HC  = 100;  // 400 ns

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic supplyLow = 1'b0;
  logic manualRstN = 1'b1;
  logic resetN, resetOe, odResetN, odResetOe;

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  rst_supervisor #(.CLK_HZ(250_000_000), .MANUAL_MIN_NS(40), .SUPPLY_MIN_NS(100),
                   .HOLD_NS(400), .OPEN_DRAIN(1'b0)) i_rst_supervisor (
    .clk(clk), .rstN(rstN), .supplyLow(supplyLow), .manualRstN(manualRstN),
    .resetN(resetN), .resetOe(resetOe));

  rst_supervisor #(.CLK_HZ(250_000_000), .MANUAL_MIN_NS(40), .SUPPLY_MIN_NS(100),
                   .HOLD_NS(400), .OPEN_DRAIN(1'b1)) i_rst_supervisor_od (
    .clk(clk), .rstN(rstN), .supplyLow(supplyLow), .manualRstN(manualRstN),
    .resetN(odResetN), .resetOe(odResetOe));

  typedef struct {
    int    due;
    bit    expN;
    string req;
  } expItem_t;

  expItem_t sb[$];
  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  task automatic expectAt(input int due, input bit v, input string req);
    expItem_t e;
    e.due = due; e.expN = v; e.req = req;
    sb.push_back(e);
  endtask

  task automatic cmp(input string req, input logic act, input logic exp, input string what);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s at cycle %0d: actual %b expected %b", req, what, cyc, act, exp);
    end
  endtask

  // monitor: pop every item due at this cycle and compare both instances
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].due == cyc) begin
        cmp(sb[i].req, resetN, sb[i].expN, "resetN");
        cmp(sb[i].req, odResetN, sb[i].expN, "open-drain resetN");
        cmp("R9", resetOe, 1'b1, "push-pull resetOe");
        cmp("R9", odResetOe, ~sb[i].expN, "open-drain resetOe");
        sb.delete(i);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    int k, r, r1, r2, t1, t2;
    step(3);
    // R1: initial timeout
    rstN = 1'b1; k = cyc;
    expectAt(k + 1, 1'b0, "R1");
    expectAt(k + HC - 2, 1'b0, "R1");
    expectAt(k + HC + 2, 1'b1, "R1");
    step(HC + 6);

    // R3: short manual pulse rejected
    k = cyc; manualRstN = 1'b0;
    step(MRC - 2); manualRstN = 1'b1;
    expectAt(k + MRC + 4, 1'b1, "R3");
    expectAt(k + MRC + 8, 1'b1, "R3");
    step(20);

    // R2 / R6: qualified manual reset and its stretch
    k = cyc; manualRstN = 1'b0;
    expectAt(k + MRC + 1, 1'b1, "R2");
    expectAt(k + MRC + 5, 1'b0, "R2");
    step(MRC + 20);
    r = cyc; manualRstN = 1'b1;
    expectAt(r + HC + 2, 1'b0, "R6");
    expectAt(r + HC + 5, 1'b1, "R6");
    step(HC + 10);

    // R5: short supply dip ignored
    k = cyc; supplyLow = 1'b1;
    step(SPC - 2); supplyLow = 1'b0;
    expectAt(k + SPC + 4, 1'b1, "R5");
    expectAt(k + SPC + 8, 1'b1, "R5");
    step(20);

    // R4 / R6: qualified supply fault
    k = cyc; supplyLow = 1'b1;
    expectAt(k + SPC + 1, 1'b1, "R4");
    expectAt(k + SPC + 5, 1'b0, "R4");
    step(SPC + 30);
    r = cyc; supplyLow = 1'b0;
    expectAt(r + HC + 2, 1'b0, "R6");
    expectAt(r + HC + 5, 1'b1, "R6");
    step(HC + 10);

    // R7: overlapping sources, timer starts at the last release
    manualRstN = 1'b0; supplyLow = 1'b1;
    step(40);
    t1 = cyc; manualRstN = 1'b1;
    step(50);
    t2 = cyc; supplyLow = 1'b0;
    expectAt(t1 + HC + 5, 1'b0, "R7");
    expectAt(t2 + HC + 2, 1'b0, "R7");
    expectAt(t2 + HC + 5, 1'b1, "R7");
    step(HC + 10);

    // R8: retrigger during the stretch reloads the full timeout
    manualRstN = 1'b0;
    step(30);
    r1 = cyc; manualRstN = 1'b1;
    step(50);
    manualRstN = 1'b0;
    step(MRC + 5);
    r2 = cyc; manualRstN = 1'b1;
    expectAt(r1 + HC + 5, 1'b0, "R8");
    expectAt(r2 + HC + 2, 1'b0, "R8");
    expectAt(r2 + HC + 5, 1'b1, "R8");
    step(HC + 10);

    step(2);
    finished = 1'b1;
    report();
  end

  // watchdog
  initial begin
    repeat (50_000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      report();
    end
  end

endmodule